// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Mask Unit

This block gathers the event sources of an I2C controller into one twelve-bit raw status vector and drives a single interrupt line from it. Ten of the sources are single-cycle pulses from the bus engine. Each pulse is held in a sticky bit until software clears it. The other two are level conditions. The receive-full bit compares the receive FIFO fill level against a programmable threshold. The transmit-empty bit compares the command FIFO fill level against a second threshold. The interrupt line is high whenever any raw status bit is also enabled in the mask register.

Software reaches the block over a simple single-cycle register bus. Read data is combinational while a read is presented. Sticky events are never cleared by a write. They are cleared by reading dedicated clear addresses: one address clears every sticky event at once, and each sticky event has its own clear address. A clear read returns whether the event was pending before the clear. The block also accumulates an abort-reason code that arrives with each transmit-abort pulse. The transmit-abort clear and the global clear both reset that code.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset the mask, both thresholds, every sticky bit and the abort-reason register are zero, and `irq` is low.
- R2: Each bit of `evt_pulse` sets one raw status bit, and that bit stays set until it is cleared. The mapping is pulse bit 0→status 0 (rx underflow), 1→1 (rx overflow), 2→3 (tx overflow), 3→5 (read request), 4→6 (tx abort), 5→7 (rx done), 6→8 (activity), 7→9 (stop), 8→10 (start), 9→11 (general call). The raw status vector is read at word address 0x03.
- R3: Raw status bit 2 is high exactly while `rx_level` is greater than the receive threshold, which is at word address 0x01. It is not latched.
- R4: Raw status bit 4 is high exactly while `tx_level` is less than or equal to the transmit threshold, which is at word address 0x02. It is not latched.
- R5: `irq` is the OR of raw status ANDed with the mask, which is at word address 0x00. That same product reads back at word address 0x04.
- R6: A read of address 0x10+n, where n is a sticky bit index, returns 1 if bit n was set and 0 if it was not. The read clears bit n from the next cycle on and leaves every other bit unchanged.
- R7: A read of address 0x08 returns 1 if any sticky bit was set and 0 otherwise. The read clears every sticky bit and the abort-reason register.
- R8: On each tx-abort pulse, `abort_code` is ORed into the abort-reason register, which is read at 0x05. A read of the tx-abort clear address 0x16 clears both that register and status bit 6.
- R9: When a pulse and a clear of the same event fall in the same cycle, the event stays set. For an abort, the register keeps only the new code. The clear read still returns the value from before that cycle.
- R10: Writing zero to the mask drops `irq` from the next cycle on, even while events stay latched.
- R11: Writes to read-only or clear addresses change nothing. A clear read aimed at a level bit (0x12 or 0x14) returns 0 and has no effect. Ordinary register reads clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while a read is presented |
| evt_pulse | input | 10 | Event pulses from the bus engine |
| abort_code | input | ABRT_W | Abort reason, sampled with the tx-abort pulse |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Command FIFO fill level |
| irq | output | 1 | Interrupt request |

## Verification
The critical overlap is an event pulse that arrives in the same cycle as a software clear read of that same event. This can happen for a plain sticky bit and for the abort-reason register. The bench provokes it by raising the pulse and presenting the clear read on one clock edge. It then checks three things: the returned value shows the old state, the status bit is still set afterwards, and the abort register holds only the fresh code. A second overlap, a mask write arriving while events stay latched, is judged by watching `irq` fall on the very next cycle while the raw status still reads non-zero.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   localparam int N_EV    = 12;
   localparam int N_PULSE = 10;

   // status bit positions
   localparam int B_RXUND = 0;
   localparam int B_RXOVF = 1;
   localparam int B_RXFUL = 2;
   localparam int B_TXOVF = 3;
   localparam int B_TXEMP = 4;
   localparam int B_RDREQ = 5;
   localparam int B_TXABT = 6;
   localparam int B_RXDON = 7;
   localparam int B_ACTIV = 8;
   localparam int B_STOP  = 9;
   localparam int B_START = 10;
   localparam int B_GCALL = 11;

   // sticky (latched) events; bits 4 and 2 are level conditions
   localparam logic [N_EV-1:0] STICKY = 12'hFEB;

   // word addresses
   localparam int A_MASK    = 0;
   localparam int A_RXTHR   = 1;
   localparam int A_TXTHR   = 2;
   localparam int A_RAW     = 3;
   localparam int A_PEND    = 4;
   localparam int A_ABRT    = 5;
   localparam int A_CLRALL  = 8;
   localparam int A_CLRBASE = 16;

   // place the engine's pulse vector onto status positions
   function automatic logic [N_EV-1:0] spread_pulses(input logic [N_PULSE-1:0] p);
      return {p[9:4], p[3], 1'b0, p[2], 1'b0, p[1:0]};
   endfunction
endpackage

// File: rtl/irqc_thresh.sv
`timescale 1ns/1ps
module irqc_thresh #(
   parameter int LVL_W      = 7,
   parameter bit SYNC_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] rx_thr,
   input  logic [LVL_W-1:0] tx_thr,
   output logic             rx_full,
   output logic             tx_empty
);
   logic rx_cmp;
   logic tx_cmp;

   assign rx_cmp = (rx_level > rx_thr);
   assign tx_cmp = (tx_level <= tx_thr);

   generate
      if (SYNC_LEVEL) begin : g_reg
         logic rx_q;
         logic tx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_q <= 1'b0;
               tx_q <= 1'b0;
            end else begin
               rx_q <= rx_cmp;
               tx_q <= tx_cmp;
            end
         end
         assign rx_full  = rx_q;
         assign tx_empty = tx_q;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign rx_full  = rx_cmp;
         assign tx_empty = tx_cmp;
      end
   endgenerate
endmodule

// File: rtl/irqc_events.sv
`timescale 1ns/1ps
module irqc_events
   import irqc_pkg::*;
#(
   parameter int ABRT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EV-1:0]   set_vec,
   input  logic [N_EV-1:0]   clr_vec,
   input  logic [ABRT_W-1:0] abort_code,
   input  logic              clr_abort,
   output logic [N_EV-1:0]   held,
   output logic [ABRT_W-1:0] abort_src
);
   logic              abt_pulse;
   logic [ABRT_W-1:0] abt_new;

   assign abt_pulse = set_vec[B_TXABT];
   assign abt_new   = abt_pulse ? abort_code : '0;

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else begin
         held <= ((held & ~clr_vec) | set_vec) & STICKY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_src <= '0;
      end else if (clr_abort) begin
         abort_src <= abt_new;
      end else begin
         abort_src <= abort_src | abt_new;
      end
   end

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & STICKY) != '0) |=> ((held & $past(set_vec & STICKY)) == $past(set_vec & STICKY)));

   assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((held & $past(clr_vec & ~set_vec)) == '0));

   assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((held & $past(held & ~clr_vec)) == $past(held & ~clr_vec)));

   assert_abort_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_abort && !abt_pulse) |=> (abort_src == '0));
endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int LVL_W  = 7,
   parameter int ABRT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [N_EV-1:0]   raw_status,
   input  logic [ABRT_W-1:0] abort_src,
   output logic [N_EV-1:0]   mask_q,
   output logic [LVL_W-1:0]  rx_thr_q,
   output logic [LVL_W-1:0]  tx_thr_q,
   output logic [N_EV-1:0]   clr_vec,
   output logic              clr_abort,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int IDX_W = $clog2(N_EV);

   logic             wr_en;
   logic             rd_en;
   logic             clr_all;
   logic             in_clr_rng;
   logic [IDX_W-1:0] clr_idx;
   logic             unused_wdata;

   assign wr_en        = bus_sel & bus_wr;
   assign rd_en        = bus_sel & ~bus_wr;
   assign clr_all      = rd_en && (bus_addr == ADDR_W'(A_CLRALL));
   assign in_clr_rng   = (bus_addr >= ADDR_W'(A_CLRBASE)) &&
                         (bus_addr <  ADDR_W'(A_CLRBASE + N_EV));
   assign clr_idx      = IDX_W'(bus_addr - ADDR_W'(A_CLRBASE));
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         rx_thr_q <= '0;
         tx_thr_q <= '0;
      end else if (wr_en) begin
         if (bus_addr == ADDR_W'(A_MASK))  mask_q   <= bus_wdata[N_EV-1:0];
         if (bus_addr == ADDR_W'(A_RXTHR)) rx_thr_q <= bus_wdata[LVL_W-1:0];
         if (bus_addr == ADDR_W'(A_TXTHR)) tx_thr_q <= bus_wdata[LVL_W-1:0];
      end
   end

   // read-side clear strobes, one per sticky event
   generate
      for (genvar i = 0; i < N_EV; i++) begin : g_clr
         if (STICKY[i]) begin : g_stk
            assign clr_vec[i] = clr_all |
                                (rd_en && (bus_addr == ADDR_W'(A_CLRBASE + i)));
         end else begin : g_lvl
            assign clr_vec[i] = 1'b0;
         end
      end
   endgenerate

   assign clr_abort = clr_vec[B_TXABT];

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         if (bus_addr == ADDR_W'(A_MASK))
            bus_rdata = DATA_W'(mask_q);
         else if (bus_addr == ADDR_W'(A_RXTHR))
            bus_rdata = DATA_W'(rx_thr_q);
         else if (bus_addr == ADDR_W'(A_TXTHR))
            bus_rdata = DATA_W'(tx_thr_q);
         else if (bus_addr == ADDR_W'(A_RAW))
            bus_rdata = DATA_W'(raw_status);
         else if (bus_addr == ADDR_W'(A_PEND))
            bus_rdata = DATA_W'(raw_status & mask_q);
         else if (bus_addr == ADDR_W'(A_ABRT))
            bus_rdata = DATA_W'(abort_src);
         else if (bus_addr == ADDR_W'(A_CLRALL))
            bus_rdata = DATA_W'(|(raw_status & STICKY));
         else if (in_clr_rng)
            bus_rdata = DATA_W'(raw_status[clr_idx] & STICKY[clr_idx]);
      end
   end

   assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |-> $onehot0(clr_vec));

   assert_no_write_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (clr_vec == '0));
endmodule

// File: rtl/i2c_irq_ctrl.sv
`timescale 1ns/1ps
module i2c_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 16,
   parameter int LVL_W      = 7,
   parameter int ABRT_W     = 16,
   parameter bit SYNC_LEVEL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [N_PULSE-1:0]  evt_pulse,
   input  logic [ABRT_W-1:0]   abort_code,
   input  logic [LVL_W-1:0]    rx_level,
   input  logic [LVL_W-1:0]    tx_level,
   output logic                irq
);
   generate
      if (DATA_W < N_EV || DATA_W < LVL_W || DATA_W < ABRT_W) begin : g_bad_width
         $error("i2c_irq_ctrl: DATA_W too narrow");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("i2c_irq_ctrl: ADDR_W must reach the clear window");
      end
   endgenerate

   logic [N_EV-1:0]   set_vec;
   logic [N_EV-1:0]   clr_vec;
   logic [N_EV-1:0]   held;
   logic [N_EV-1:0]   lvl_vec;
   logic [N_EV-1:0]   raw_status;
   logic [N_EV-1:0]   mask_q;
   logic [LVL_W-1:0]  rx_thr_q;
   logic [LVL_W-1:0]  tx_thr_q;
   logic [ABRT_W-1:0] abort_src;
   logic              clr_abort;
   logic              rx_full;
   logic              tx_empty;

   assign set_vec = spread_pulses(evt_pulse);

   irqc_thresh #(.LVL_W(LVL_W), .SYNC_LEVEL(SYNC_LEVEL)) u_thresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_level (rx_level),
      .tx_level (tx_level),
      .rx_thr   (rx_thr_q),
      .tx_thr   (tx_thr_q),
      .rx_full  (rx_full),
      .tx_empty (tx_empty)
   );

   irqc_events #(.ABRT_W(ABRT_W)) u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec),
      .clr_vec    (clr_vec),
      .abort_code (abort_code),
      .clr_abort  (clr_abort),
      .held       (held),
      .abort_src  (abort_src)
   );

   irqc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .ABRT_W(ABRT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .raw_status (raw_status),
      .abort_src  (abort_src),
      .mask_q     (mask_q),
      .rx_thr_q   (rx_thr_q),
      .tx_thr_q   (tx_thr_q),
      .clr_vec    (clr_vec),
      .clr_abort  (clr_abort),
      .bus_rdata  (bus_rdata)
   );

   always_comb begin
      lvl_vec          = '0;
      lvl_vec[B_RXFUL] = rx_full;
      lvl_vec[B_TXEMP] = tx_empty;
   end

   assign raw_status = held | lvl_vec;
   assign irq        = |(raw_status & mask_q);

   assert_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(A_MASK) && bus_wdata[N_EV-1:0] == '0)
      |=> !irq);
endmodule

// File: tb/tb_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_irq_ctrl;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 16;
   localparam int LVL_W  = 7;
   localparam int ABRT_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_sel;
   logic              bus_wr;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic [9:0]        evt_pulse;
   logic [ABRT_W-1:0] abort_code;
   logic [LVL_W-1:0]  rx_level;
   logic [LVL_W-1:0]  tx_level;
   logic              irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   i2c_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_pulse(evt_pulse), .abort_code(abort_code),
      .rx_level(rx_level), .tx_level(tx_level), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] pulse_to_status(input logic [9:0] p);
      int pos [10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
      logic [11:0] r = '0;
      for (int k = 0; k < 10; k++) if (p[k]) r[pos[k]] = 1'b1;
      return r;
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input logic [9:0] p, input logic [15:0] code);
      @(negedge clk);
      evt_pulse = p; abort_code = code;
      @(negedge clk);
      evt_pulse = '0; abort_code = '0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R1 irq after reset", 32'(irq), 0);
      rd(0, d); chk("R1 mask reset", 32'(d), 0);
      rd(1, d); chk("R1 rx threshold reset", 32'(d), 0);
      rd(2, d); chk("R1 tx threshold reset", 32'(d), 0);
      rd(5, d); chk("R1 abort reason reset", 32'(d), 0);
      rd(3, d); chk("R1 raw status reset (only tx-empty level)", 32'(d), 32'h010);
   endtask

   task automatic t_sticky;
      logic [15:0] d;
      for (int k = 0; k < 10; k++) begin
         pulse(10'(1 << k), 16'h0001);
         repeat (3) @(negedge clk);
         rd(3, d);
         chk($sformatf("R2 pulse bit %0d held", k), 32'(d),
             32'(pulse_to_status(10'(1 << k)) | 12'h010));
         rd(8, d);
      end
   endtask

   task automatic t_levels;
      logic [15:0] d;
      wr(1, 16'd5);
      rx_level = 7'd5; rd(3, d); chk("R3 rx level equal to threshold", 32'(d[2]), 0);
      rx_level = 7'd6; rd(3, d); chk("R3 rx level above threshold", 32'(d[2]), 1);
      rx_level = 7'd2; rd(3, d); chk("R3 rx full not latched", 32'(d[2]), 0);
      wr(2, 16'd3);
      tx_level = 7'd3; rd(3, d); chk("R4 tx level equal to threshold", 32'(d[4]), 1);
      tx_level = 7'd4; rd(3, d); chk("R4 tx level above threshold", 32'(d[4]), 0);
      tx_level = 7'd0; rd(3, d); chk("R4 tx empty returns", 32'(d[4]), 1);
      rx_level = 7'd0; wr(1, 16'd0); wr(2, 16'd0);
   endtask

   task automatic t_mask;
      logic [15:0] d;
      wr(0, 16'h002);
      #1 chk("R5 no irq without event", 32'(irq), 0);
      pulse(10'b10, 16'h0);
      #1 chk("R5 irq on masked event", 32'(irq), 1);
      rd(4, d); chk("R5 pending readback", 32'(d), 32'h002);
      wr(0, 16'h000);
      #1 chk("R10 irq drops after mask cleared", 32'(irq), 0);
      rd(3, d); chk("R10 event still latched", 32'(d[1]), 1);
      wr(0, 16'h004);
      rx_level = 7'd1; #1 chk("R5 irq follows rx full level", 32'(irq), 1);
      rx_level = 7'd0; #1 chk("R5 irq falls with level", 32'(irq), 0);
      wr(0, 16'h000);
      rd(8, d);
   endtask

   task automatic t_clear_each;
      logic [15:0] d;
      pulse(10'b101, 16'h0);
      rd(16'h10, d); chk("R6 clear read returns set", 32'(d), 1);
      rd(3, d); chk("R6 only target bit cleared", 32'(d), 32'h018);
      rd(16'h10, d); chk("R6 second clear returns 0", 32'(d), 0);
      rd(16'h13, d); chk("R6 clear bit 3", 32'(d), 1);
      rd(3, d); chk("R6 bit 3 gone", 32'(d), 32'h010);
   endtask

   task automatic t_clear_all;
      logic [15:0] d;
      rd(8, d); chk("R7 global clear with nothing set", 32'(d), 0);
      pulse(10'b11_0000_0010, 16'h0);
      rd(8, d); chk("R7 global clear returns 1", 32'(d), 1);
      rd(3, d); chk("R7 all sticky bits cleared", 32'(d), 32'h010);
   endtask

   task automatic t_abort;
      logic [15:0] d;
      pulse(10'b1_0000, 16'h0005);
      pulse(10'b1_0000, 16'h0030);
      rd(5, d); chk("R8 abort reasons accumulate", 32'(d), 32'h0035);
      rd(16'h16, d); chk("R8 abort clear returns 1", 32'(d), 1);
      rd(5, d); chk("R8 abort reason cleared", 32'(d), 0);
      rd(3, d); chk("R8 abort status cleared", 32'(d[6]), 0);
      pulse(10'b1_0000, 16'h0100);
      rd(8, d);
      rd(5, d); chk("R7 global clear wipes abort reason", 32'(d), 0);
   endtask

   task automatic t_collision;
      logic [15:0] d;
      pulse(10'b10, 16'h0);
      @(negedge clk);
      evt_pulse = 10'b10; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(16'h11);
      #1 d = bus_rdata;
      @(negedge clk);
      evt_pulse = '0; bus_sel = 1'b0;
      chk("R9 clear read returns old value", 32'(d), 1);
      rd(3, d); chk("R9 set beats clear", 32'(d[1]), 1);
      pulse(10'b1_0000, 16'h0001);
      @(negedge clk);
      evt_pulse = 10'b1_0000; abort_code = 16'h0008;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(16'h16);
      #1 d = bus_rdata;
      @(negedge clk);
      evt_pulse = '0; abort_code = '0; bus_sel = 1'b0;
      chk("R9 abort clear returns old value", 32'(d), 1);
      rd(5, d); chk("R9 abort keeps only new code", 32'(d), 32'h0008);
      rd(3, d); chk("R9 abort status stays", 32'(d[6]), 1);
      rd(8, d);
   endtask

   task automatic t_ignored;
      logic [15:0] d;
      pulse(10'b1, 16'h0);
      wr(8, 16'hFFFF);
      wr(16'h10, 16'hFFFF);
      wr(3, 16'hFFFF);
      rd(3, d); chk("R11 writes clear nothing", 32'(d), 32'h011);
      rd(16'h14, d); chk("R11 level clear returns 0", 32'(d), 0);
      rd(16'h12, d); chk("R11 rx full clear returns 0", 32'(d), 0);
      rd(0, d);
      rd(3, d); chk("R11 plain reads clear nothing", 32'(d), 32'h011);
      rd(8, d);
   endtask

   task automatic finish_run;
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      evt_pulse = '0; abort_code = '0; rx_level = '0; tx_level = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_sticky();
      t_levels();
      t_mask();
      t_clear_each();
      t_clear_all();
      t_abort();
      t_collision();
      t_ignored();
      finish_run();
   end
endmodule